// File: doc/BRIEF.md
# Registered Integer Execute Unit

This block is the arithmetic core of an execute stage. Each cycle it takes two data operands, a shift amount, a 16-bit immediate and a 4-bit operation code. It computes the chosen function and stores the outcome in a result register on the rising clock edge. The registered output can drive the execute-to-memory pipeline boundary directly, so the unit sits between operand selection and the next stage register.

The unit offers wrapping add and subtract, a multiply that keeps the low half of the product, bitwise AND and OR, and a signed set-less-than. It also has a left shift that fills with zeros, and an add-immediate. Load and store address generation uses the add-immediate path. There are no flags, no traps and no division.

Top module: `xalu`

## Requirements
- R1: While `rst_n` is low, `result` is zero. After reset is released, `result` stays zero until the first edge with `rst_n` high.
- R2: Inputs sampled on a rising edge with `rst_n` high appear on `result` after that edge, which gives one cycle of latency. A new operation may be issued on every cycle.
- R3: Op code 4'h0 (add) gives `opnd_a + opnd_b` modulo 2^32 and wraps on overflow.
- R4: Op code 4'h1 (subtract) gives `opnd_a - opnd_b` modulo 2^32 and wraps on underflow.
- R5: Op code 4'h2 (multiply) gives the low 32 bits of `opnd_a * opnd_b`.
- R6: Op code 4'h3 gives bitwise `opnd_a & opnd_b`. Op code 4'h4 gives bitwise `opnd_a | opnd_b`.
- R7: Op code 4'h5 (set-less-than) gives 1 when `opnd_a` is below `opnd_b` as two's complement signed values, and 0 otherwise. This includes the case where the two are equal.
- R8: Op code 4'h6 (shift) gives `opnd_b` shifted left by `shamt` bit positions (0 to 31), with zeros entering at the low end.
- R9: Op code 4'h7 (add-immediate and address generation) gives `opnd_a` plus `imm` sign-extended from bit 15, modulo 2^32.
- R10: Op codes 4'h8 to 4'hF are unrecognised and give a result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation code |
| opnd_a | input | 32 | First operand (rs) |
| opnd_b | input | 32 | Second operand (rt), also the shift source |
| shamt | input | 5 | Shift distance |
| imm | input | 16 | Immediate, sign-extended internally |
| result | output | 32 | Registered result |

## Verification
The bench builds the unit with its default widths: 32-bit data, a 5-bit shift amount and a 16-bit immediate. At these widths the signed boundary pair 0x80000000 and 0x7FFFFFFF can be reached, along with all-ones carry and borrow chains, a multiply whose true product overflows 32 bits, and shifts of 0 and of the full 31 positions. Negative and maximum positive immediates exercise the sign extension. Back-to-back issue and a reset asserted in the middle of the stream exercise the register timing.

// File: rtl/xalu_pkg.sv
package xalu_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        XOP_ADD  = 4'h0,
        XOP_SUB  = 4'h1,
        XOP_MUL  = 4'h2,
        XOP_AND  = 4'h3,
        XOP_OR   = 4'h4,
        XOP_SLT  = 4'h5,
        XOP_SHL  = 4'h6,
        XOP_ADDI = 4'h7
    } xop_e;
endpackage

// File: rtl/xalu_arith.sv
module xalu_arith #(
    parameter int W     = 32,
    parameter int IMM_W = 16
) (
    input  logic [W-1:0]     a,
    input  logic [W-1:0]     b,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     sum,
    output logic [W-1:0]     diff,
    output logic [W-1:0]     prod,
    output logic [W-1:0]     sum_imm
);
    localparam int EXT_W = W - IMM_W;

    logic [W-1:0] imm_ext;

    // Sign extension of the immediate
    assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

    // Results are truncated to W bits, so every path wraps
    always_comb begin
        sum     = a + b;
        diff    = a - b;
        prod    = a * b;
        sum_imm = a + imm_ext;
    end
endmodule

// File: rtl/xalu_logic.sv
module xalu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] and_o,
    output logic [W-1:0] or_o,
    output logic [W-1:0] slt_o
);
    logic lt;

    always_comb begin
        and_o = a & b;
        or_o  = a | b;
        lt    = ($signed(a) < $signed(b));
        slt_o = {{(W-1){1'b0}}, lt};
    end
endmodule

// File: rtl/xalu_shift.sv
module xalu_shift #(
    parameter int W   = 32,
    parameter int SHW = 5
) (
    input  logic [W-1:0]   src,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dst
);
    logic [W-1:0] stage [0:SHW];

    assign stage[0] = src;

    // Logarithmic shifter: stage i moves by 2**i when amt[i] is set
    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int STEP = 1 << i;
        assign stage[i+1] = amt[i] ? {stage[i][W-1-STEP:0], {STEP{1'b0}}}
                                   : stage[i];
    end

    assign dst = stage[SHW];
endmodule

// File: rtl/xalu.sv
module xalu
    import xalu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 5,
    parameter int IMM_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    op_sel,
    input  logic [DATA_W-1:0]  opnd_a,
    input  logic [DATA_W-1:0]  opnd_b,
    input  logic [SHAMT_W-1:0] shamt,
    input  logic [IMM_W-1:0]   imm,
    output logic [DATA_W-1:0]  result
);
    logic [DATA_W-1:0] r_sum, r_diff, r_prod, r_addi;
    logic [DATA_W-1:0] r_and, r_or, r_slt, r_shl;
    logic [DATA_W-1:0] next_result;

    xalu_arith #(.W(DATA_W), .IMM_W(IMM_W)) u_arith (
        .a       (opnd_a),
        .b       (opnd_b),
        .imm     (imm),
        .sum     (r_sum),
        .diff    (r_diff),
        .prod    (r_prod),
        .sum_imm (r_addi)
    );

    xalu_logic #(.W(DATA_W)) u_logic (
        .a     (opnd_a),
        .b     (opnd_b),
        .and_o (r_and),
        .or_o  (r_or),
        .slt_o (r_slt)
    );

    xalu_shift #(.W(DATA_W), .SHW(SHAMT_W)) u_shift (
        .src (opnd_b),
        .amt (shamt),
        .dst (r_shl)
    );

    // Result select; any code outside the defined set yields zero
    always_comb begin
        case (op_sel)
            XOP_ADD:  next_result = r_sum;
            XOP_SUB:  next_result = r_diff;
            XOP_MUL:  next_result = r_prod;
            XOP_AND:  next_result = r_and;
            XOP_OR:   next_result = r_or;
            XOP_SLT:  next_result = r_slt;
            XOP_SHL:  next_result = r_shl;
            XOP_ADDI: next_result = r_addi;
            default:  next_result = '0;
        endcase
    end

    // Result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result <= '0;
        else        result <= next_result;
    end
endmodule

// File: rtl/xalu_checker.sv
module xalu_checker
    import xalu_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SHAMT_W = 5,
    parameter int IMM_W   = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [OP_W-1:0]    op_sel,
    input logic [DATA_W-1:0]  opnd_a,
    input logic [DATA_W-1:0]  opnd_b,
    input logic [SHAMT_W-1:0] shamt,
    input logic [IMM_W-1:0]   imm,
    input logic [DATA_W-1:0]  result
);
    // warm is set when the previous edge saw reset released
    logic warm;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm <= 1'b0;
        else        warm <= 1'b1;
    end

    // R1: reset holds the result at zero
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_zero_r1: assert (result == '0)
                else $error("R1 result nonzero in reset");
        end
    end

    p_add_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(op_sel) == XOP_ADD) |-> result == $past(opnd_a) + $past(opnd_b));

    p_and_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(op_sel) == XOP_AND) |-> result == ($past(opnd_a) & $past(opnd_b)));

    p_slt_bool_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(op_sel) == XOP_SLT) |-> result[DATA_W-1:1] == '0);

    p_shl_lowzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(op_sel) == XOP_SHL) |->
            (result & ((DATA_W'(1) << $past(shamt)) - DATA_W'(1))) == '0);

    p_unknown_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(op_sel) > XOP_ADDI) |-> result == '0);
endmodule

bind xalu xalu_checker #(
    .DATA_W  (DATA_W),
    .SHAMT_W (SHAMT_W),
    .IMM_W   (IMM_W)
) u_xalu_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_sel (op_sel),
    .opnd_a (opnd_a),
    .opnd_b (opnd_b),
    .shamt  (shamt),
    .imm    (imm),
    .result (result)
);

// File: tb/xalu_bench.sv
module xalu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  shamt = '0;
    logic [15:0] imm = '0;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        int          due;
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t q[$];

    xalu u_xalu (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .shamt(shamt), .imm(imm), .result(result)
    );

    always #10 clk = ~clk;   // 50 MHz

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Monitor: compares results due this cycle at mid-period
    always @(posedge clk) begin
        cyc++;
        #10;
        while (q.size() > 0 && q[0].due == cyc) begin
            check(q[0].req, result, q[0].exp);
            void'(q.pop_front());
        end
    end

    function automatic logic [31:0] model(input logic [3:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [4:0] s,
                                          input logic [15:0] im);
        logic [63:0] p;
        case (op)
            4'h0: return a + b;
            4'h1: return a - b;
            4'h2: begin p = {32'b0, a} * {32'b0, b}; return p[31:0]; end
            4'h3: return a & b;
            4'h4: return a | b;
            4'h5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            4'h6: return b << s;
            4'h7: return a + {{16{im[15]}}, im};
            default: return 32'd0;
        endcase
    endfunction

    // Driver: issues after an edge, result due after the next edge
    task automatic issue(input string req, input logic [3:0] op, input logic [31:0] a,
                         input logic [31:0] b, input logic [4:0] s, input logic [15:0] im);
        item_t it;
        @(posedge clk);
        #2;
        op_sel = op; opnd_a = a; opnd_b = b; shamt = s; imm = im;
        it.due = cyc + 1;
        it.exp = model(op, a, b, s, im);
        it.req = req;
        q.push_back(it);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, with nonzero inputs present
        op_sel = 4'h4; opnd_a = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #10 check("R1", result, 32'h0);
        @(posedge clk); #2 rst_n = 1'b1;
        #8 check("R1", result, 32'h0);

        // R2: back-to-back issue, one per cycle
        issue("R2", 4'h0, 32'd5, 32'd6, 5'd0, 16'h0);
        issue("R2", 4'h1, 32'd5, 32'd6, 5'd0, 16'h0);
        issue("R3", 4'h0, 32'hFFFF_FFFF, 32'd1, 5'd0, 16'h0);
        issue("R3", 4'h0, 32'h7FFF_FFFF, 32'd1, 5'd0, 16'h0);
        issue("R4", 4'h1, 32'd0, 32'd1, 5'd0, 16'h0);
        issue("R4", 4'h1, 32'h8000_0000, 32'd1, 5'd0, 16'h0);
        issue("R5", 4'h2, 32'h0001_0000, 32'h0001_0000, 5'd0, 16'h0);
        issue("R5", 4'h2, 32'd7, 32'hFFFF_FFFD, 5'd0, 16'h0);
        issue("R5", 4'h2, 32'h1234_5678, 32'h9ABC_DEF1, 5'd0, 16'h0);
        issue("R6", 4'h3, 32'hF0F0_A5A5, 32'hFF00_0FF0, 5'd0, 16'h0);
        issue("R6", 4'h4, 32'hF0F0_A5A5, 32'h0F00_0FF0, 5'd0, 16'h0);
        issue("R7", 4'h5, 32'hFFFF_FFFF, 32'd1, 5'd0, 16'h0);
        issue("R7", 4'h5, 32'd1, 32'hFFFF_FFFF, 5'd0, 16'h0);
        issue("R7", 4'h5, 32'd9, 32'd9, 5'd0, 16'h0);
        issue("R7", 4'h5, 32'h8000_0000, 32'h7FFF_FFFF, 5'd0, 16'h0);
        issue("R7", 4'h5, 32'd3, 32'd4, 5'd0, 16'h0);
        issue("R8", 4'h6, 32'h0, 32'd1, 5'd31, 16'h0);
        issue("R8", 4'h6, 32'h0, 32'hFFFF_FFFF, 5'd4, 16'h0);
        issue("R8", 4'h6, 32'h0, 32'hDEAD_BEEF, 5'd0, 16'h0);
        issue("R8", 4'h6, 32'h0, 32'h8765_4321, 5'd13, 16'h0);
        issue("R9", 4'h7, 32'd10, 32'h0, 5'd0, 16'hFFFF);
        issue("R9", 4'h7, 32'h1000, 32'h0, 5'd0, 16'h7FFF);
        issue("R9", 4'h7, 32'h0, 32'h0, 5'd0, 16'h8000);
        issue("R10", 4'h8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3, 16'hFFFF);
        issue("R10", 4'hF, 32'h1234_5678, 32'h1, 5'd1, 16'h1);
        issue("R10", 4'hB, 32'h5, 32'h5, 5'd0, 16'h0);
        // A flush to a known value after unknown op codes
        issue("R2", 4'h4, 32'hA, 32'h5, 5'd0, 16'h0);
        repeat (3) @(posedge clk);

        // R1: reset asserted mid-stream clears the register
        issue("R1", 4'h4, 32'hFFFF_0000, 32'h0000_FFFF, 5'd0, 16'h0);
        repeat (2) @(posedge clk);
        #4 rst_n = 1'b0;
        #2 check("R1", result, 32'h0);
        @(posedge clk); #2 rst_n = 1'b1;
        #8 check("R1", result, 32'h0);
        issue("R3", 4'h0, 32'd100, 32'd23, 5'd0, 16'h0);
        repeat (3) @(posedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule